// File: doc/BRIEF.md
# Trigger Supervisor Control Logic

This block stands between the source of physics triggers and a set of readout controllers. Each incoming trigger pulse, or a debug trigger fired by a register write, is sent out one cycle later as a pulse on a separate line for every readout unit whose partition mask bit is clear. Triggers are dropped while the block reports busy, while a synchronisation cycle runs, and in the cycle that starts one.

A sync request opens a synchronisation cycle. The cycle closes when every unmasked unit reports that it has finished. At that moment the block samples each unit's mismatch flag, which tells whether the unit's trigger number disagrees with the front ends. The active-low sync-failure output is low for the whole cycle. After a mismatch it stays low until a host reset. The block turns the readout status into a busy output, which suspends trigger generation, and a halt output, which stops acquisition. It records why halt was raised in sticky cause bits. It also counts dead time, meaning the clock cycles spent busy.

A small register port, with registered writes and combinational reads, holds the masks and the transfer timeout. The same port fires soft triggers, issues host resets and reads back the cause bits and the dead-time count.

Top module: `trig_sup`

## Requirements
- R1: After reset, trig_out is 0, busy and halt are 0, sync_fail_n is 1, and the mask (address 0) and dead-time (address 5) registers read 0.
- R2: A trig_in pulse produces trig_out = ~mask on the next cycle, for exactly one cycle. Bit i of the mask register at address 0 suppresses unit i.
- R3: A write of 1 in bit 0 to address 1 fires a soft trigger with the same timing and masking as trig_in. A write with bit 0 clear fires nothing.
- R4: A trigger is not forwarded while busy is 1, while a sync cycle is active, or in the cycle in which sync_req is high.
- R5: A sync_req pulse starts a sync cycle, with sync_fail_n low from the next cycle. The cycle ends on the first cycle in which every unmasked unit has ru_sync_done high. sync_fail_n returns high one cycle later if no mismatch was sampled. Masked units are not waited for.
- R6: If any unmasked ru_sync_bad is high when the sync cycle ends, sync_fail_n stays low and halt rises with cause bit 2. Both remain until a host reset, which is a write of 1 in bit 0 to address 3. Mismatch from masked units is ignored.
- R7: busy rises one cycle after any unmasked unit drives ru_busy_n low or raises ru_fifo_full. Masked units are ignored. busy is also 1 whenever halt is 1.
- R8: One cycle after any unmasked ru_err_n goes low, halt rises with cause bit 0. It stays high after the error clears, until a host reset.
- R9: Address 2 holds the timeout limit L. A cycle in which an unmasked ru_xfer is high after L consecutive such cycles raises halt with cause bit 1, so a transfer lasting L cycles is allowed and L+1 cycles times out. L = 0 disables the check.
- R10: The dead-time counter at address 5 adds one for every cycle in which busy is 1, and saturates at its maximum. A read of address 5 returns the count and clears it.
- R11: The mask and timeout registers read back the last value written. The cause bits read at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 1 | External trigger pulse |
| sync_req | input | 1 | Sync cycle request pulse |
| ru_busy_n | input | N_UNITS | Per-unit busy, active low |
| ru_fifo_full | input | N_UNITS | Per-unit trigger queue full |
| ru_err_n | input | N_UNITS | Per-unit error, active low |
| ru_xfer | input | N_UNITS | Per-unit readout transfer in progress |
| ru_sync_done | input | N_UNITS | Per-unit sync finished |
| ru_sync_bad | input | N_UNITS | Per-unit trigger number mismatch |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| trig_out | output | N_UNITS | Dispatched trigger pulse per unit |
| busy | output | 1 | Suspend triggering |
| halt | output | 1 | Stop acquisition |
| sync_fail_n | output | 1 | Sync in progress or failed, active low |

## Verification
The bench builds the block with its defaults: four units and 16-bit register data. With four units, all sixteen partition masks can be swept for dispatch, for soft triggers and for sync completion. Every unit can also be tried both masked and unmasked as a source of busy and of error. The 16-bit timeout register lets the bench program a limit of a few cycles, so the cycle at which a transfer times out, and the disabled case, can each be hit exactly.

// File: rtl/trgs_pkg.sv
package trgs_pkg;
    localparam logic [2:0] A_MASK  = 3'd0;
    localparam logic [2:0] A_SOFT  = 3'd1;
    localparam logic [2:0] A_TMO   = 3'd2;
    localparam logic [2:0] A_CTRL  = 3'd3;
    localparam logic [2:0] A_CAUSE = 3'd4;
    localparam logic [2:0] A_DEAD  = 3'd5;

    localparam int CAUSE_W = 3;
    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/trgs_regs.sv
module trgs_regs
    import trgs_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int DATA_W  = 16,
    parameter int TO_INIT = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               re,
    input  logic [2:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    input  cause_t             cause,
    input  logic [DATA_W-1:0]  dead,
    output logic [DATA_W-1:0]  rdata,
    output logic [N_UNITS-1:0] mask,
    output logic [DATA_W-1:0]  to_lim,
    output logic               soft_fire,
    output logic               host_clr,
    output logic               dead_clr
);
    typedef struct packed {
        logic [N_UNITS-1:0] mask;
        logic [DATA_W-1:0]  to_lim;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (we) begin
            case (addr)
                A_MASK:  d.mask   = wdata[N_UNITS-1:0];
                A_TMO:   d.to_lim = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mask   <= '0;
            q.to_lim <= DATA_W'(TO_INIT);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MASK:  rdata = DATA_W'(q.mask);
            A_TMO:   rdata = q.to_lim;
            A_CAUSE: rdata = DATA_W'(cause);
            A_DEAD:  rdata = dead;
            default: rdata = '0;
        endcase
    end

    assign mask      = q.mask;
    assign to_lim    = q.to_lim;
    assign soft_fire = we && (addr == A_SOFT) && wdata[0];
    assign host_clr  = we && (addr == A_CTRL) && wdata[0];
    assign dead_clr  = re && (addr == A_DEAD);
endmodule

// File: rtl/trgs_sync.sv
module trgs_sync #(
    parameter int N_UNITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_req,
    input  logic [N_UNITS-1:0] done,
    input  logic [N_UNITS-1:0] bad,
    input  logic [N_UNITS-1:0] mask,
    input  logic               host_clr,
    output logic               active,
    output logic               fail_set,
    output logic               sync_fail_n
);
    typedef struct packed {
        logic active;
        logic failed;
    } sync_t;

    sync_t q, d;
    logic  finish;
    logic  mismatch;

    always_comb begin
        finish   = q.active && (&(done | mask));
        mismatch = |(bad & ~mask);
        fail_set = finish && mismatch;
        d        = q;
        if (q.active) begin
            d.active = !finish;
        end else begin
            d.active = sync_req;
        end
        d.failed = q.failed | fail_set;
        if (host_clr) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active      = q.active;
    assign sync_fail_n = !(q.active || q.failed);
endmodule

// File: rtl/trgs_guard.sv
module trgs_guard
    import trgs_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UNITS-1:0] busy_n,
    input  logic [N_UNITS-1:0] fifo_full,
    input  logic [N_UNITS-1:0] err_n,
    input  logic [N_UNITS-1:0] xfer,
    input  logic [N_UNITS-1:0] mask,
    input  logic [DATA_W-1:0]  to_lim,
    input  logic               sync_fail_set,
    input  logic               host_clr,
    input  logic               dead_clr,
    output logic               busy,
    output logic               halt,
    output cause_t             cause,
    output logic [DATA_W-1:0]  dead
);
    typedef struct packed {
        cause_t             cause;
        logic               busy;
        logic [DATA_W-1:0]  to_cnt;
        logic [DATA_W-1:0]  dead;
    } guard_t;

    guard_t q, d;
    logic   xfer_any, err_any, busy_any, full_any, tmo;

    always_comb begin
        xfer_any = |(xfer & ~mask);
        err_any  = |(~err_n & ~mask);
        busy_any = |(~busy_n & ~mask);
        full_any = |(fifo_full & ~mask);
        tmo      = xfer_any && (to_lim != '0) && (q.to_cnt >= to_lim);

        d = q;
        if (xfer_any) begin
            d.to_cnt = (q.to_cnt == '1) ? q.to_cnt : q.to_cnt + 1'b1;
        end else begin
            d.to_cnt = '0;
        end
        d.cause = q.cause | cause_t'({sync_fail_set, tmo, err_any});
        if (host_clr) begin
            d.cause  = '0;
            d.to_cnt = '0;
        end
        d.busy = busy_any || full_any || (|d.cause);
        if (dead_clr) begin
            d.dead = '0;
        end else if (q.busy && (q.dead != '1)) begin
            d.dead = q.dead + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy  = q.busy;
    assign halt  = |q.cause;
    assign cause = q.cause;
    assign dead  = q.dead;
endmodule

// File: rtl/trgs_fanout.sv
module trgs_fanout #(
    parameter int N_UNITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_in,
    input  logic               soft_fire,
    input  logic [N_UNITS-1:0] mask,
    input  logic               block,
    output logic [N_UNITS-1:0] trig_out
);
    typedef struct packed {
        logic [N_UNITS-1:0] trig;
    } fan_t;

    fan_t               q, d;
    logic               fire;
    logic [N_UNITS-1:0] pass;

    assign fire = trig_in | soft_fire;

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        assign pass[i] = fire & ~mask[i];
    end

    always_comb begin
        d      = q;
        d.trig = block ? '0 : pass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign trig_out = q.trig;
endmodule

// File: rtl/trig_sup.sv
module trig_sup
    import trgs_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int DATA_W  = 16,
    parameter int TO_INIT = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_in,
    input  logic               sync_req,
    input  logic [N_UNITS-1:0] ru_busy_n,
    input  logic [N_UNITS-1:0] ru_fifo_full,
    input  logic [N_UNITS-1:0] ru_err_n,
    input  logic [N_UNITS-1:0] ru_xfer,
    input  logic [N_UNITS-1:0] ru_sync_done,
    input  logic [N_UNITS-1:0] ru_sync_bad,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [2:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [N_UNITS-1:0] trig_out,
    output logic               busy,
    output logic               halt,
    output logic               sync_fail_n
);
    logic [N_UNITS-1:0] mask_w;
    logic [DATA_W-1:0]  to_lim_w;
    logic [DATA_W-1:0]  dead_w;
    cause_t             cause_w;
    logic               soft_w, host_clr_w, dead_clr_w;
    logic               sync_active_w, fail_set_w, block_w;

    trgs_regs #(.N_UNITS(N_UNITS), .DATA_W(DATA_W), .TO_INIT(TO_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .re(reg_re), .addr(reg_addr),
        .wdata(reg_wdata), .cause(cause_w), .dead(dead_w), .rdata(reg_rdata),
        .mask(mask_w), .to_lim(to_lim_w), .soft_fire(soft_w),
        .host_clr(host_clr_w), .dead_clr(dead_clr_w)
    );

    trgs_sync #(.N_UNITS(N_UNITS)) u_sync (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .done(ru_sync_done),
        .bad(ru_sync_bad), .mask(mask_w), .host_clr(host_clr_w),
        .active(sync_active_w), .fail_set(fail_set_w), .sync_fail_n(sync_fail_n)
    );

    trgs_guard #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .busy_n(ru_busy_n), .fifo_full(ru_fifo_full),
        .err_n(ru_err_n), .xfer(ru_xfer), .mask(mask_w), .to_lim(to_lim_w),
        .sync_fail_set(fail_set_w), .host_clr(host_clr_w), .dead_clr(dead_clr_w),
        .busy(busy), .halt(halt), .cause(cause_w), .dead(dead_w)
    );

    assign block_w = sync_active_w | sync_req | busy;

    trgs_fanout #(.N_UNITS(N_UNITS)) u_fan (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .soft_fire(soft_w),
        .mask(mask_w), .block(block_w), .trig_out(trig_out)
    );
endmodule

// File: rtl/trig_sup_chk.sv
module trig_sup_chk #(
    parameter int N_UNITS = 4,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_UNITS-1:0] trig_out,
    input logic [N_UNITS-1:0] mask,
    input logic               sync_active,
    input logic               busy,
    input logic               halt,
    input logic               sync_fail_n,
    input logic               host_clr,
    input logic [DATA_W-1:0]  dead,
    input logic               dead_clr
);
    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((trig_out & $past(mask)) == '0));

    assert_sync_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_active |=> (trig_out == '0));

    assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (trig_out == '0));

    assert_sync_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_active |-> !sync_fail_n);

    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_active && !sync_fail_n && !host_clr) |=> !sync_fail_n);

    assert_halt_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> busy);

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !host_clr) |=> halt);

    assert_dead_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dead_clr && (dead != '1)) |=> (dead == $past(dead) + 1'b1));
endmodule

bind trig_sup trig_sup_chk #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .mask(mask_w),
    .sync_active(sync_active_w), .busy(busy), .halt(halt),
    .sync_fail_n(sync_fail_n), .host_clr(host_clr_w), .dead(dead_w),
    .dead_clr(dead_clr_w)
);

// File: tb/tb_trig_sup.sv
module tb_trig_sup;
    import trgs_pkg::*;

    localparam int N = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0, sync_req = 1'b0;
    logic [N-1:0]  ru_busy_n = '1, ru_fifo_full = '0, ru_err_n = '1;
    logic [N-1:0]  ru_xfer = '0, ru_sync_done = '0, ru_sync_bad = '0;
    logic          reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  trig_out;
    logic          busy, halt, sync_fail_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] rv;

    always #10 clk = ~clk;

    trig_sup #(.N_UNITS(N), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sync_req(sync_req),
        .ru_busy_n(ru_busy_n), .ru_fifo_full(ru_fifo_full), .ru_err_n(ru_err_n),
        .ru_xfer(ru_xfer), .ru_sync_done(ru_sync_done), .ru_sync_bad(ru_sync_bad),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_out(trig_out),
        .busy(busy), .halt(halt), .sync_fail_n(sync_fail_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
        reg_re = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic pulse_trig();
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic pulse_sync();
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
    endtask

    task automatic finish_sync();
        ru_sync_done = '1;
        @(negedge clk);
        ru_sync_done = '0;
        ru_sync_bad  = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 trig_out", 32'(trig_out), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 halt", 32'(halt), 0);
        check("R1 sync_fail_n", 32'(sync_fail_n), 1);
        rd(A_MASK, rv); check("R1 mask", 32'(rv), 0);
        rd(A_DEAD, rv); check("R1 dead", 32'(rv), 0);

        // R2 / R11 dispatch under every mask
        for (int m = 0; m < 16; m++) begin
            wr(A_MASK, DW'(m));
            rd(A_MASK, rv); check("R11 mask readback", 32'(rv), 32'(m));
            pulse_trig();
            check("R2 dispatch", 32'(trig_out), 32'((~m) & 15));
            @(negedge clk);
            check("R2 single pulse", 32'(trig_out), 0);
        end

        // R3 soft trigger
        for (int m = 0; m < 16; m++) begin
            wr(A_MASK, DW'(m));
            wr(A_SOFT, 1);
            check("R3 soft fire", 32'(trig_out), 32'((~m) & 15));
            wr(A_SOFT, 2);
            check("R3 bit0 clear", 32'(trig_out), 0);
        end

        // R5 sync completion for every mask
        for (int m = 0; m < 16; m++) begin
            wr(A_MASK, DW'(m));
            pulse_sync();
            check("R5 low during sync", 32'(sync_fail_n), 0);
            if (m != 15) begin
                ru_sync_done = N'(m);
                @(negedge clk);
                check("R5 waits unmasked", 32'(sync_fail_n), 0);
            end
            ru_sync_done = N'((~m) & 15);
            @(negedge clk);
            ru_sync_done = '0;
            check("R5 ends", 32'(sync_fail_n), 1);
        end

        // R4 sync blocks triggers
        wr(A_MASK, 0);
        pulse_sync();
        pulse_trig();
        check("R4 blocked in sync", 32'(trig_out), 0);
        finish_sync();
        check("R4 sync over", 32'(sync_fail_n), 1);
        pulse_trig();
        check("R4 passes after sync", 32'(trig_out), 15);
        sync_req = 1'b1; trig_in = 1'b1;
        @(negedge clk);
        sync_req = 1'b0; trig_in = 1'b0;
        check("R4 same cycle as sync_req", 32'(trig_out), 0);
        finish_sync();

        // R6 mismatch
        wr(A_MASK, 4'b0010);
        pulse_sync();
        ru_sync_bad = 4'b0010;
        finish_sync();
        check("R6 masked mismatch fail_n", 32'(sync_fail_n), 1);
        check("R6 masked mismatch halt", 32'(halt), 0);
        pulse_sync();
        ru_sync_bad = 4'b0100;
        finish_sync();
        check("R6 fail_n latched", 32'(sync_fail_n), 0);
        check("R6 halt", 32'(halt), 1);
        check("R6 busy", 32'(busy), 1);
        repeat (3) @(negedge clk);
        check("R6 still latched", 32'(sync_fail_n), 0);
        rd(A_CAUSE, rv); check("R6 cause", 32'(rv), 4);
        wr(A_CTRL, 1);
        check("R6 host reset fail_n", 32'(sync_fail_n), 1);
        check("R6 host reset halt", 32'(halt), 0);
        check("R6 host reset busy", 32'(busy), 0);

        // R7 busy sources per unit, masked and unmasked
        for (int u = 0; u < N; u++) begin
            for (int mk = 0; mk < 2; mk++) begin
                wr(A_MASK, DW'(mk << u));
                ru_busy_n = ~N'(1 << u);
                @(negedge clk);
                check("R7 busy line", 32'(busy), 32'(1 - mk));
                ru_busy_n = '1;
                @(negedge clk);
                check("R7 busy release", 32'(busy), 0);
                ru_fifo_full = N'(1 << u);
                @(negedge clk);
                check("R7 fifo full", 32'(busy), 32'(1 - mk));
                ru_fifo_full = '0;
                @(negedge clk);
            end
        end

        // R4 busy blocks triggers
        wr(A_MASK, 0);
        ru_busy_n = 4'b1110;
        @(negedge clk);
        pulse_trig();
        check("R4 blocked by busy", 32'(trig_out), 0);
        ru_busy_n = '1;
        @(negedge clk);

        // R8 error line
        for (int u = 0; u < N; u++) begin
            wr(A_MASK, DW'(1 << u));
            ru_err_n = ~N'(1 << u);
            @(negedge clk);
            check("R8 masked error", 32'(halt), 0);
            ru_err_n = '1;
            wr(A_MASK, 0);
            ru_err_n = ~N'(1 << u);
            @(negedge clk);
            check("R8 halt", 32'(halt), 1);
            check("R8 busy with halt", 32'(busy), 1);
            ru_err_n = '1;
            repeat (3) @(negedge clk);
            check("R8 sticky", 32'(halt), 1);
            rd(A_CAUSE, rv); check("R8 cause", 32'(rv), 1);
            wr(A_CTRL, 1);
            check("R8 host reset", 32'(halt), 0);
        end

        // R9 timeout
        wr(A_TMO, 5);
        rd(A_TMO, rv); check("R11 timeout readback", 32'(rv), 5);
        ru_xfer = 4'b0001;
        repeat (5) @(negedge clk);
        ru_xfer = '0;
        @(negedge clk);
        check("R9 at limit no halt", 32'(halt), 0);
        ru_xfer = 4'b1000;
        repeat (6) @(negedge clk);
        check("R9 over limit halt", 32'(halt), 1);
        ru_xfer = '0;
        rd(A_CAUSE, rv); check("R9 cause", 32'(rv), 2);
        wr(A_CTRL, 1);
        wr(A_MASK, 4'b0100);
        wr(A_TMO, 2);
        ru_xfer = 4'b0100;
        repeat (10) @(negedge clk);
        check("R9 masked transfer", 32'(halt), 0);
        ru_xfer = '0;
        wr(A_MASK, 0);
        wr(A_TMO, 0);
        ru_xfer = 4'b0010;
        repeat (20) @(negedge clk);
        check("R9 disabled", 32'(halt), 0);
        ru_xfer = '0;
        @(negedge clk);

        // R10 dead time
        rd(A_DEAD, rv);
        for (int k = 1; k < 9; k += 3) begin
            ru_busy_n = 4'b1011;
            repeat (k) @(negedge clk);
            ru_busy_n = '1;
            @(negedge clk);
            rd(A_DEAD, rv); check("R10 dead count", 32'(rv), 32'(k));
        end
        rd(A_DEAD, rv); check("R10 cleared by read", 32'(rv), 0);

        summary();
    end
endmodule